// File: doc/BRIEF.md
# Tick-Paced Buffered Serial Transmitter

This block sends bytes as asynchronous serial frames. A producer writes bytes into a 32-entry circular buffer, which stores each byte complemented. The block has no baud generator of its own. It puts exactly one bit period on the line for every pulse on `tick`. That pulse can be any periodic strobe in the system, such as a converter's conversion-done signal that runs near 125 kHz / 13, or about 9600 bit/s. Between pulses the line holds its level.

The line output assumes an external inverting driver, so every level on `txd` is the inverse of a standard frame. Idle and stop bits are low, the start bit is high, and each data bit appears as its complement, least significant bit first. A frame is 11 ticks long: one start bit, eight data bits and two stop bits. When one frame ends and another byte is waiting, the next frame starts on the very next tick.

The write side is a valid/ready stream. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops while 32 bytes are waiting, and at that point the producer must hold off. A write offered while `in_ready` is low is discarded, and the buffer contents do not change. The `empty` output tells the system that all queued data has left the line.

Top module: `tick_uart_tx`

## Requirements
- R1: After reset, `txd` is low, `empty` is high and `in_ready` is high.
- R2: A byte is stored on each clock edge where `in_valid` and `in_ready` are both high. The buffer holds up to 32 bytes, and `in_ready` is low exactly while 32 bytes are waiting.
- R3: A write offered while `in_ready` is low is discarded. The bytes sent afterwards are exactly the 32 that were accepted, in order, with nothing extra.
- R4: `txd` changes only on the clock edge that samples `tick` high. With `tick` low it holds its level.
- R5: On the first tick that fetches a byte, `txd` goes high. This is the start bit.
- R6: On each of the next 8 ticks, `txd` equals the complement of data bits 0 through 7 in turn, least significant bit first.
- R7: On the 2 ticks after the data bits, `txd` is low. These are the stop bits.
- R8: A byte is fetched only on a tick where no bits of the previous frame remain and the buffer is not empty. A tick with nothing to send leaves `txd` low. Queued bytes go out in write order, back to back.
- R9: `empty` is high only when the buffer holds no bytes and no bits of a frame remain to be sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Write byte offered |
| in_ready | output | 1 | Buffer can accept a byte (low = full) |
| in_data | input | 8 | Byte to transmit |
| tick | input | 1 | One-cycle pacing pulse, one bit period per pulse |
| txd | output | 1 | Serial line, inverted polarity |
| empty | output | 1 | No bytes queued and no bits left to send |

## Verification
Some rules are checked by assertions on every cycle: the line holds between ticks, stop-bit ticks drive the line low, the buffer never holds more than its depth, no byte is taken while a frame is in progress, and the line is low whenever `empty` is high. Other behaviour needs the bench's scenarios. Bit-exact frame contents and order under random tick spacing can only be confirmed there, as can the discard of a write to a full buffer and the back-to-back start of queued frames. The bench compares each frame against one it computes from the written bytes.

// File: rtl/tut_pkg.sv
`timescale 1ns/1ps
package tut_pkg;
  // number of bit periods after the start bit
  function automatic int tail_len(input int dw, input int stop);
    return dw + stop;
  endfunction
endpackage

// File: rtl/tut_ring.sv
`timescale 1ns/1ps
module tut_ring #(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  output logic          push_ready,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          is_empty
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] store [DEPTH];
  logic [AW:0]   wr_idx, rd_idx;
  logic          full, push_fire;

  assign is_empty  = (wr_idx == rd_idx);
  assign full      = (wr_idx[AW] != rd_idx[AW]) && (wr_idx[AW-1:0] == rd_idx[AW-1:0]);
  assign push_ready = !full;
  assign push_fire = push_valid && !full;
  assign pop_data  = store[rd_idx[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_fire) store[wr_idx[AW-1:0]] <= ~push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
    end else begin
      if (push_fire) wr_idx <= wr_idx + 1'b1;
      if (pop)       rd_idx <= rd_idx + 1'b1;
    end
  end

  // R2
  occupancy_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx - rd_idx) <= (AW+1)'(DEPTH));

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> $stable(wr_idx));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !is_empty);
endmodule

// File: rtl/tut_serializer.sv
`timescale 1ns/1ps
module tut_serializer
  import tut_pkg::*;
#(
  parameter int DW   = 8,
  parameter int STOP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          avail,
  input  logic [DW-1:0] load_data,
  output logic          take,
  output logic          txd,
  output logic          busy
);
  localparam int FL = tail_len(DW, STOP);
  localparam int CW = $clog2(FL + 1);

  logic [DW-1:0] shreg;
  logic [CW-1:0] left;

  assign busy = (left != '0);
  assign take = tick && !busy && avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
      txd   <= 1'b0;
    end else if (tick) begin
      if (busy) begin
        txd   <= shreg[0];
        shreg <= shreg >> 1;
        left  <= left - 1'b1;
      end else if (avail) begin
        shreg <= load_data;
        left  <= CW'(FL);
        txd   <= 1'b1;
      end
    end
  end

  // R7
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && busy && left <= CW'(STOP)) |=> !txd);

  // R4
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd));

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left <= CW'(FL));
endmodule

// File: rtl/tick_uart_tx.sv
`timescale 1ns/1ps
module tick_uart_tx #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int STOP  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          tick,
  output logic          txd,
  output logic          empty
);
  logic          ring_empty, take, busy;
  logic [DW-1:0] head;

  tut_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .push_valid(in_valid), .push_ready(in_ready), .push_data(in_data),
    .pop(take), .pop_data(head), .is_empty(ring_empty)
  );

  tut_serializer #(.DW(DW), .STOP(STOP)) u_ser (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .avail(!ring_empty), .load_data(head),
    .take(take), .txd(txd), .busy(busy)
  );

  assign empty = ring_empty && !busy;

  // R9
  empty_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !txd);

  // R8
  fetch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> $rose(busy));
endmodule

// File: tb/tick_uart_tx_test.sv
`timescale 1ns/1ps
module tick_uart_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       tick = 1'b0;
  logic       in_ready, txd, empty;

  int checks = 0;
  int errors = 0;
  logic [7:0] pending[$];

  always #2 clk = ~clk;

  tick_uart_tx uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tick(tick), .txd(txd), .empty(empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected line level for bit position p (0 = start) of a frame carrying b
  function automatic logic line_bit(input logic [7:0] b, input int p);
    if (p == 0) return 1'b1;
    if (p <= 8) return ~b[p-1];
    return 1'b0;
  endfunction

  task automatic push(input logic [7:0] b, input bit expect_take);
    @(negedge clk);
    chk(in_ready == expect_take, "R2 ready", in_ready, expect_take);
    in_valid = 1'b1;
    in_data  = b;
    if (in_ready) pending.push_back(b);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic gap();
    logic lvl;
    int n;
    lvl = txd;
    n = $urandom % 4;
    for (int i = 0; i < n; i++) @(negedge clk);
    if (n != 0) chk(txd == lvl, "R4 hold", txd, lvl);
  endtask

  task automatic send_one(input bit random_gaps);
    logic [7:0] b;
    logic e;
    b = pending.pop_front();
    for (int p = 0; p < 11; p++) begin
      pulse();
      e = line_bit(b, p);
      if (p == 0)      chk(txd == e, "R5 start", txd, e);
      else if (p <= 8) chk(txd == e, "R6 data", txd, e);
      else             chk(txd == e, "R7 stop", txd, e);
      if (p < 10) chk(empty == 1'b0, "R9 busy", empty, 0);
      if (random_gaps) gap();
    end
  endtask

  task automatic drain(input bit random_gaps);
    while (pending.size() != 0) send_one(random_gaps);
    @(negedge clk);
    chk(empty == 1'b1, "R9 drained", empty, 1);
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20061));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(txd == 1'b0, "R1 txd", txd, 0);
    chk(empty == 1'b1, "R1 empty", empty, 1);
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);

    // R8: ticks with nothing queued keep the line low
    for (int i = 0; i < 3; i++) begin
      pulse();
      chk(txd == 1'b0, "R8 idle tick", txd, 0);
      chk(empty == 1'b1, "R8 idle empty", empty, 1);
    end

    // directed byte, then no tick for a while: line must hold
    push(8'hA5, 1'b1);
    chk(empty == 1'b0, "R9 queued", empty, 0);
    repeat (5) @(negedge clk);
    chk(txd == 1'b0, "R4 no tick", txd, 0);
    drain(1'b0);

    // corner values
    push(8'h00, 1'b1);
    push(8'hFF, 1'b1);
    push(8'h01, 1'b1);
    push(8'h80, 1'b1);
    drain(1'b1);

    // random batches with random tick spacing
    for (int k = 0; k < 6; k++) begin
      int n;
      n = 1 + ($urandom % 4);
      for (int j = 0; j < n; j++) push(8'($urandom), 1'b1);
      drain(1'b1);
    end

    // write while a frame is on the line
    push(8'h3C, 1'b1);
    pulse();
    pulse();
    pending.push_front(8'h00);
    begin
      logic [7:0] first;
      first = pending[1];
      pending.delete(0);
      push(8'hC3, 1'b1);
      // remaining bits of the first frame (positions 2..10)
      for (int p = 2; p < 11; p++) begin
        pulse();
        chk(txd == line_bit(first, p), "R6 mid-frame", txd, line_bit(first, p));
      end
      void'(pending.pop_front());
    end
    // next tick immediately starts the queued byte
    drain(1'b0);

    // fill to capacity
    for (int j = 0; j < 32; j++) push(8'($urandom), 1'b1);
    @(negedge clk);
    chk(in_ready == 1'b0, "R2 full", in_ready, 0);
    push(8'h5A, 1'b0);  // R3: refused
    chk(pending.size() == 32, "R3 count", pending.size(), 32);
    drain(1'b0);
    // R3: nothing extra follows the accepted bytes
    pulse();
    chk(txd == 1'b0, "R3 no extra", txd, 0);
    chk(empty == 1'b1, "R3 empty", empty, 1);
    chk(in_ready == 1'b1, "R2 ready again", in_ready, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule